// File: doc/BRIEF.md
# 32-bit Four-Mode Shift Unit

A purely combinational shifter for the execute stage of a register-machine processor. It takes a 5-bit opcode, the operand read from the first source register and the value of a second source register. It also takes a 5-bit count field from the instruction. From these it produces the shifted result together with a flag that says the opcode selected a shift.

Four opcodes are recognised: a right shift that fills with zeros, a right shift that fills with the sign bit, a left shift that fills with zeros, and a left rotate. The amount comes from the instruction's count field unless that field is zero; in that case the low five bits of the second register supply it. Writeback to the register file and all non-shift operations belong to neighbouring logic.

Top module: `shift_unit`

## Requirements
- R1: With opcode 26 the result is the operand shifted right by n, with the vacated upper n bits set to 0.
- R2: With opcode 27 the result is the operand shifted right by n, with the vacated upper n bits equal to operand bit 31.
- R3: With opcode 28 the result is the operand shifted left by n, with the vacated lower n bits set to 0.
- R4: With opcode 29 the result is the operand rotated left by n: bit i of the operand appears at bit (i+n) mod 32.
- R5: When the 5-bit count field is nonzero, n equals that field and the register count input has no effect.
- R6: When the count field is zero, n equals bits 4..0 of the register count input; bits 31..5 of that input have no effect.
- R7: When n is 0, every shift opcode returns the operand unchanged.
- R8: The valid flag is 1 exactly for opcodes 26 to 29; for any other opcode the flag is 0 and the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation code; 26..29 select the shift kinds |
| src_val | input | 32 | Operand to be shifted |
| cnt_reg | input | 32 | Register value; its low 5 bits give the count when the count field is zero |
| cnt_imm | input | 5 | Count field from the instruction |
| res | output | 32 | Shift result, zero for non-shift opcodes |
| res_ok | output | 1 | High when the opcode is a shift |

## Verification
The assertions assume the inputs are stable when they are sampled. They are evaluated as combinational checks, so they rely on the opcode, operand and both count sources settling together. The bench changes all inputs at one edge and compares on the opposite edge. It sweeps all eight opcodes from 24 to 31, every count-field value, and every low-five-bit register count while the field is zero. It uses random upper register bits throughout, so the width of the count path never leaves the 0 to 31 range.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int WIDTH = 32
) (
  input  logic [4:0]                 op_code,
  input  logic [WIDTH-1:0]           src_val,
  input  logic [WIDTH-1:0]           cnt_reg,
  input  logic [$clog2(WIDTH)-1:0]   cnt_imm,
  output logic [WIDTH-1:0]           res,
  output logic                       res_ok
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [4:0] OP_LSR = 5'd26;
  localparam logic [4:0] OP_ASR = 5'd27;
  localparam logic [4:0] OP_LSL = 5'd28;
  localparam logic [4:0] OP_ROL = 5'd29;

  logic [CW-1:0]    n;
  logic [CW-1:0]    amt;
  logic             go_right;
  logic [WIDTH-1:0] stg [0:CW];
  logic [WIDTH-1:0] keep_l, keep_r;
  logic [WIDTH-1:0] rot;
  wire              unused_hi = ^cnt_reg[WIDTH-1:CW];

  assign n        = (cnt_imm != '0) ? cnt_imm : cnt_reg[CW-1:0];
  assign go_right = (op_code == OP_LSR) || (op_code == OP_ASR);
  assign amt      = go_right ? (CW'(0) - n) : n;
  assign stg[0]   = src_val;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 2 ** k;
    assign stg[k+1] = amt[k] ? {stg[k][WIDTH-1-S:0], stg[k][WIDTH-1:WIDTH-S]} : stg[k];
  end

  assign rot = stg[CW];

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign keep_l[i] = (i >= int'(n));
    assign keep_r[i] = ((i + int'(n)) < WIDTH);
  end

  always_comb begin
    res_ok = 1'b1;
    case (op_code)
      OP_LSR:  res = rot & keep_r;
      OP_ASR:  res = (rot & keep_r) | ({WIDTH{src_val[WIDTH-1]}} & ~keep_r);
      OP_LSL:  res = rot & keep_l;
      OP_ROL:  res = rot;
      default: begin
        res    = '0;
        res_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic [4:0]               op_code,
  input logic [WIDTH-1:0]         src_val,
  input logic [WIDTH-1:0]         cnt_reg,
  input logic [$clog2(WIDTH)-1:0] cnt_imm,
  input logic [WIDTH-1:0]         res,
  input logic                     res_ok
);
  localparam int CW = $clog2(WIDTH);
  logic [CW-1:0] cn;
  logic          is_sh;
  wire           unused_chk = ^cnt_reg[WIDTH-1:CW];

  assign cn    = (cnt_imm != '0) ? cnt_imm : cnt_reg[CW-1:0];
  assign is_sh = (op_code >= 5'd26) && (op_code <= 5'd29);

  always_comb begin
    AST_FLAG_MATCH: assert (res_ok == is_sh);                                        // R8
    AST_IDLE_ZERO:  assert (res_ok || res == '0);                                    // R8
    AST_ZERO_PASS:  assert (!(is_sh && cn == '0) || res == src_val);                 // R7
    AST_ROT_POP:    assert (op_code != 5'd29 || $countones(res) == $countones(src_val)); // R4
    AST_SIGN_KEEP:  assert (op_code != 5'd27 || res[WIDTH-1] == src_val[WIDTH-1]);   // R2
    AST_LSR_TOP:    assert (op_code != 5'd26 || cn == '0 || !res[WIDTH-1]);          // R1
    AST_LSL_BOT:    assert (op_code != 5'd28 || cn == '0 || !res[0]);                // R3
  end
endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .op_code(op_code), .src_val(src_val), .cnt_reg(cnt_reg),
  .cnt_imm(cnt_imm), .res(res), .res_ok(res_ok)
);

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] src_val = '0;
  logic [31:0] cnt_reg = '0;
  logic [4:0]  cnt_imm = '0;
  logic [31:0] res;
  logic        res_ok;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit u0 (
    .op_code(op_code), .src_val(src_val), .cnt_reg(cnt_reg),
    .cnt_imm(cnt_imm), .res(res), .res_ok(res_ok)
  );

  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] s, input int n);
    case (op)
      5'd26: return s >> n;
      5'd27: return 32'($signed(s) >>> n);
      5'd28: return s << n;
      5'd29: return (n == 0) ? s : ((s << n) | (s >> (32 - n)));
      default: return 32'h0;
    endcase
  endfunction

  task automatic run_one(input logic [4:0] op, input logic [31:0] s,
                         input logic [31:0] rc, input logic [4:0] imm);
    int n;
    logic [31:0] exp_r;
    logic exp_ok;
    string tag;
    @(posedge clk);
    op_code = op; src_val = s; cnt_reg = rc; cnt_imm = imm;
    n      = (imm != 0) ? int'(imm) : int'(rc[4:0]);
    exp_r  = model(op, s, n);
    exp_ok = (op >= 5'd26) && (op <= 5'd29);
    if (!exp_ok)       tag = "R8";
    else if (n == 0)   tag = "R7";
    else if (imm == 0) tag = $sformatf("R%0d/R6", op - 5'd25);
    else               tag = $sformatf("R%0d/R5", op - 5'd25);
    @(negedge clk);
    checks++;
    if (res !== exp_r || res_ok !== exp_ok) begin
      errors++;
      $display("FAIL %s op=%0d src=%h rc=%h imm=%0d: got res=%h ok=%b, expected res=%h ok=%b",
               tag, op, s, rc, imm, res, res_ok, exp_r, exp_ok);
    end
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0000;
    pats[3] = 32'h7FFF_FFFE; pats[4] = 32'hA5C3_0F96; pats[5] = $urandom;
    @(negedge clk);
    checks++;
    if (res !== 32'h0 || res_ok !== 1'b0) begin
      errors++;
      $display("FAIL R8 initial op 0: got res=%h ok=%b, expected res=0 ok=0", res, res_ok);
    end
    for (int p = 0; p < 6; p++) begin
      for (int op = 24; op < 32; op++) begin
        for (int imm = 1; imm < 32; imm++)
          run_one(5'(op), pats[p], {$urandom} ^ 32'(imm ^ 21), 5'(imm));
        for (int lo = 0; lo < 32; lo++)
          run_one(5'(op), pats[p], {27'($urandom), 5'(lo)}, 5'd0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule